// File: doc/BRIEF.md
# Product-Term Logic Cell

This block is a configurable logic cell. It has eighteen logic inputs and four outputs. A bank of twenty product terms is built from the inputs. Each term can use any input in true form, in complemented form, or not at all. For each output, a wide OR sum can gather any subset of the terms, and an optional XOR against a dedicated term follows it. This lets the cell build parity and counter-style logic.

Each output also has a short path that ORs a fixed group of four terms and skips both the wide allocation and the XOR stage. After the logic, each output can be taken combinationally or from a flip-flop. That flip-flop is clocked by one of three global clocks, chosen per output.

The whole configuration is a set of static parallel vectors. The four outputs are repeated on a feedback port so that neighbouring cells can use them as inputs.

Top module: `lc_glb`

## Requirements
- R1: Product term p is the AND of every input i whose true-select bit `cfg_and_t[p*18+i]` is 1, and of the complement of every input whose complement-select bit `cfg_and_c[p*18+i]` is 1. A term that selects both forms of one input is always 0.
- R2: A product term with no select bit set evaluates to 0, so it adds nothing to any sum.
- R3: When an output's short path and XOR are both off, its logic value is the OR of the terms p whose allocation bit `cfg_alloc[o*20+p]` is 1. With no allocation bits set, the value is 0.
- R4: When `cfg_xor[o]` is 1 and the short path is off, the logic value is the wide sum XOR product term 16+o.
- R5: When `cfg_fast[o]` is 1, the logic value is the OR of product terms 4o to 4o+3. The allocation bits and `cfg_xor[o]` have no effect on that output.
- R6: With `cfg_reg[o]` = 0, `q[o]` follows the logic value with no clock edge.
- R7: With `cfg_reg[o]` = 1, `q[o]` takes the logic value only at a rising edge of the clock picked by `cfg_clk[2o+1:2o]`. Code 0 picks `gclk[0]`, code 1 picks `gclk[1]`, and codes 2 and 3 pick `gclk[2]`. The output holds its value through input changes and through edges on the other clocks.
- R8: While `rst` is high, every registered output reads 0, at once and with no clock. Combinational outputs are unaffected.
- R9: `fb` always equals `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 3 | Global clocks, one per bit |
| rst | input | 1 | Asynchronous reset of the output flip-flops, active high |
| lin | input | 18 | Logic inputs |
| cfg_and_t | input | 360 | True-literal select, bit p*18+i |
| cfg_and_c | input | 360 | Complement-literal select, bit p*18+i |
| cfg_alloc | input | 80 | Wide-sum allocation, bit o*20+p |
| cfg_fast | input | 4 | Short four-term path enable per output |
| cfg_xor | input | 4 | XOR stage enable per output |
| cfg_reg | input | 4 | 1 = registered, 0 = combinational |
| cfg_clk | input | 8 | Clock code per output, two bits each |
| q | output | 4 | Cell outputs |
| fb | output | 4 | Feedback copy of the outputs |

## Verification
Combinational results have no register on their path. The bench therefore checks them one time unit after it drives the inputs, with no clock edge in between. A registered output changes in the same time step as the rising edge of its own clock. The bench checks it one time unit after that edge, and checks it again after input changes and after edges on the other clocks, to show it held. The reset result is also due with no clock: the bench checks it one time unit after raising `rst` in the middle of an idle period.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int unsigned LC_N_IN    = 18;
  localparam int unsigned LC_N_PT    = 20;
  localparam int unsigned LC_N_OUT   = 4;
  localparam int unsigned LC_GRP     = 4;
  localparam int unsigned LC_N_CLK   = 3;

  // Maps a clock code to the clock it picks. Codes past the last clock
  // pick the last clock.
  function automatic int unsigned clk_index(input int unsigned code,
                                            input int unsigned nclk);
    return (code >= nclk) ? nclk - 1 : code;
  endfunction
endpackage

// File: rtl/lc_and_plane.sv
module lc_and_plane #(
  parameter int unsigned N_IN = lc_pkg::LC_N_IN,
  parameter int unsigned N_PT = lc_pkg::LC_N_PT
) (
  input  logic [N_IN-1:0]      lin,
  input  logic [N_PT*N_IN-1:0] sel_t,
  input  logic [N_PT*N_IN-1:0] sel_c,
  output logic [N_PT-1:0]      pterm
);
  for (genvar p = 0; p < N_PT; p++) begin : g_term
    logic [N_IN-1:0] mt, mc;
    logic            used;
    assign mt   = sel_t[p*N_IN +: N_IN];
    assign mc   = sel_c[p*N_IN +: N_IN];
    assign used = |(mt | mc);
    // Every selected literal must be true; a term with no literal reads 0.
    assign pterm[p] = used & (&(lin | ~mt)) & (&(~lin | ~mc));
  end
endmodule

// File: rtl/lc_sum_xor.sv
module lc_sum_xor #(
  parameter int unsigned N_PT = lc_pkg::LC_N_PT,
  parameter int unsigned GRP  = lc_pkg::LC_GRP,
  parameter int unsigned IDX  = 0,
  parameter int unsigned XPT  = 16
) (
  input  logic [N_PT-1:0] pterm,
  input  logic [N_PT-1:0] alloc,
  input  logic            fast,
  input  logic            xen,
  output logic            val
);
  logic wide, quick;
  assign wide  = |(pterm & alloc);
  assign quick = |pterm[IDX*GRP +: GRP];

  always_comb begin
    if (fast)     val = quick;
    else if (xen) val = wide ^ pterm[XPT];
    else          val = wide;
  end
endmodule

// File: rtl/lc_out_cell.sv
module lc_out_cell #(
  parameter int unsigned N_CLK = lc_pkg::LC_N_CLK,
  localparam int unsigned CSW  = (N_CLK > 1) ? $clog2(N_CLK) : 1
) (
  input  logic [N_CLK-1:0] gclk,
  input  logic             rst,
  input  logic             d,
  input  logic             reg_en,
  input  logic [CSW-1:0]   code,
  output logic             q
);
  logic [N_CLK-1:0] bank;
  logic [CSW-1:0]   pick;

  assign pick = CSW'(lc_pkg::clk_index(int'(code), N_CLK));

  for (genvar k = 0; k < N_CLK; k++) begin : g_dom
    logic hold;
    always_ff @(posedge gclk[k] or posedge rst) begin
      if (rst)                   hold <= 1'b0;
      else if (pick == CSW'(k))  hold <= d;
    end
    assign bank[k] = hold;
  end

  assign q = reg_en ? bank[pick] : d;
endmodule

// File: rtl/lc_glb.sv
module lc_glb #(
  parameter int unsigned N_IN  = lc_pkg::LC_N_IN,
  parameter int unsigned N_PT  = lc_pkg::LC_N_PT,
  parameter int unsigned N_OUT = lc_pkg::LC_N_OUT,
  parameter int unsigned GRP   = lc_pkg::LC_GRP,
  parameter int unsigned N_CLK = lc_pkg::LC_N_CLK,
  localparam int unsigned CSW  = (N_CLK > 1) ? $clog2(N_CLK) : 1,
  localparam int unsigned XBASE = N_PT - N_OUT
) (
  input  logic [N_CLK-1:0]      gclk,
  input  logic                  rst,
  input  logic [N_IN-1:0]       lin,
  input  logic [N_PT*N_IN-1:0]  cfg_and_t,
  input  logic [N_PT*N_IN-1:0]  cfg_and_c,
  input  logic [N_OUT*N_PT-1:0] cfg_alloc,
  input  logic [N_OUT-1:0]      cfg_fast,
  input  logic [N_OUT-1:0]      cfg_xor,
  input  logic [N_OUT-1:0]      cfg_reg,
  input  logic [N_OUT*CSW-1:0]  cfg_clk,
  output logic [N_OUT-1:0]      q,
  output logic [N_OUT-1:0]      fb
);
  logic [N_PT-1:0]  pterm;
  logic [N_OUT-1:0] nxt;

  lc_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
    .lin(lin), .sel_t(cfg_and_t), .sel_c(cfg_and_c), .pterm(pterm)
  );

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    lc_sum_xor #(.N_PT(N_PT), .GRP(GRP), .IDX(o), .XPT(XBASE + o)) u_sum (
      .pterm(pterm), .alloc(cfg_alloc[o*N_PT +: N_PT]),
      .fast(cfg_fast[o]), .xen(cfg_xor[o]), .val(nxt[o])
    );
    lc_out_cell #(.N_CLK(N_CLK)) u_cell (
      .gclk(gclk), .rst(rst), .d(nxt[o]), .reg_en(cfg_reg[o]),
      .code(cfg_clk[o*CSW +: CSW]), .q(q[o])
    );
  end

  assign fb = q;
endmodule

// File: rtl/lc_glb_chk.sv
module lc_glb_chk #(
  parameter int unsigned N_IN  = 18,
  parameter int unsigned N_PT  = 20,
  parameter int unsigned N_OUT = 4,
  parameter int unsigned GRP   = 4,
  parameter int unsigned CSW   = 2
) (
  input logic [2:0]            gclk,
  input logic                  rst,
  input logic [N_PT*N_IN-1:0]  cfg_and_t,
  input logic [N_PT*N_IN-1:0]  cfg_and_c,
  input logic [N_OUT-1:0]      cfg_fast,
  input logic [N_OUT-1:0]      cfg_reg,
  input logic [N_OUT*CSW-1:0]  cfg_clk,
  input logic [N_PT-1:0]       pterm,
  input logic [N_OUT-1:0]      nxt,
  input logic [N_OUT-1:0]      q
);
  logic armed;
  always_ff @(posedge gclk[0] or posedge rst) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  for (genvar p = 0; p < N_PT; p++) begin : g_pt
    // R2
    a_r2_empty_term: assert property (@(posedge gclk[0]) disable iff (rst)
      (~|(cfg_and_t[p*N_IN +: N_IN] | cfg_and_c[p*N_IN +: N_IN])) |-> !pterm[p]);
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_o
    // R5
    a_r5_fast_group: assert property (@(posedge gclk[0]) disable iff (rst)
      (cfg_fast[o] && !(|pterm[o*GRP +: GRP])) |-> !nxt[o]);
    // R6
    a_r6_comb_follow: assert property (@(posedge gclk[0]) disable iff (rst)
      !cfg_reg[o] |-> (q[o] == nxt[o]));
    // R7
    a_r7_reg_capture: assert property (@(posedge gclk[0]) disable iff (rst)
      (armed && cfg_reg[o] && $stable(cfg_reg[o]) &&
       cfg_clk[o*CSW +: CSW] == '0 && $stable(cfg_clk[o*CSW +: CSW]))
      |-> (q[o] == $past(nxt[o])));
  end
endmodule

bind lc_glb lc_glb_chk #(.N_IN(N_IN), .N_PT(N_PT), .N_OUT(N_OUT), .GRP(GRP), .CSW(CSW)) u_chk (
  .gclk(gclk), .rst(rst), .cfg_and_t(cfg_and_t), .cfg_and_c(cfg_and_c),
  .cfg_fast(cfg_fast), .cfg_reg(cfg_reg), .cfg_clk(cfg_clk),
  .pterm(pterm), .nxt(nxt), .q(q)
);

// File: tb/sim_lc_glb.sv
module sim_lc_glb;
  localparam int NI = 18, NP = 20, NO = 4;

  logic [2:0]       gclk = '0;
  logic             rst  = 1'b1;
  logic [NI-1:0]    lin  = '0;
  logic [NP*NI-1:0] cfg_and_t = '0, cfg_and_c = '0;
  logic [NO*NP-1:0] cfg_alloc = '0;
  logic [NO-1:0]    cfg_fast = '0, cfg_xor = '0, cfg_reg = '0;
  logic [NO*2-1:0]  cfg_clk = '0;
  logic [NO-1:0]    q, fb;

  int total = 0, bad = 0;
  bit done = 0;
  logic [NI-1:0] mt [NP];
  logic [NI-1:0] mc [NP];
  logic [NO-1:0] held;

  lc_glb u0 (.gclk(gclk), .rst(rst), .lin(lin), .cfg_and_t(cfg_and_t),
    .cfg_and_c(cfg_and_c), .cfg_alloc(cfg_alloc), .cfg_fast(cfg_fast),
    .cfg_xor(cfg_xor), .cfg_reg(cfg_reg), .cfg_clk(cfg_clk), .q(q), .fb(fb));

  task automatic chk(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%b exp=%b lin=%h t=%0t", req, got, exp, lin, $time);
    end
  endtask

  function automatic logic pt_m(input int p, input logic [NI-1:0] v);
    if ((mt[p] | mc[p]) == '0) return 1'b0;
    return ((v & mt[p]) == mt[p]) && ((~v & mc[p]) == mc[p]);
  endfunction

  function automatic logic out_m(input int o, input logic [NI-1:0] v);
    logic s = 1'b0;
    if (cfg_fast[o]) begin
      for (int p = 4*o; p < 4*o+4; p++) s |= pt_m(p, v);
      return s;
    end
    for (int p = 0; p < NP; p++) if (cfg_alloc[o*NP+p]) s |= pt_m(p, v);
    if (cfg_xor[o]) s ^= pt_m(NP-NO+o, v);
    return s;
  endfunction

  function automatic int eff(input int o);
    int c = int'(cfg_clk[2*o +: 2]);
    return (c > 2) ? 2 : c;
  endfunction

  task automatic pack();
    for (int p = 0; p < NP; p++) begin
      cfg_and_t[p*NI +: NI] = mt[p];
      cfg_and_c[p*NI +: NI] = mc[p];
    end
  endtask

  task automatic pulse(input int k);
    gclk[k] = 1'b1; #2; gclk[k] = 1'b0; #2;
  endtask

  function automatic logic [NI-1:0] pat(input int i);
    logic [31:0] x = 32'h9E37_79B9 * (i + 1);
    return NI'(x ^ (x >> 13));
  endfunction

  task automatic sweep_comb(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      lin = pat(i); #1;
      for (int o = 0; o < NO; o++) begin
        chk(tag, q[o], out_m(o, lin));
        chk("R9", fb[o], q[o]);
      end
      #3;
    end
  endtask

  initial begin
    #(200000*4);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) begin mt[p] = '0; mc[p] = '0; end
    mt[0]  = 18'h00003;                   // lin0 & lin1
    mc[1]  = 18'h00004;                   // ~lin2
    mt[2]  = 18'h20008; mc[2] = 18'h00010; // lin3 & lin17 & ~lin4
    mt[4]  = 18'h00020;                   // lin5
    mt[5]  = 18'h000C0;                   // lin6 & lin7
    mt[8]  = 18'h00100; mc[8] = 18'h00200;
    mt[12] = 18'h00400;
    mt[16] = 18'h00800;
    mt[17] = 18'h01000; mc[17] = 18'h02000;
    mt[18] = 18'h04000; mc[18] = 18'h04000; // contradiction
    mc[19] = 18'h10000;
    pack();

    // Reset state: all outputs registered, rst high from time zero.
    cfg_reg = 4'hF; lin = 18'h3FFFF; #3;
    for (int o = 0; o < NO; o++) chk("R8 reset state", q[o], 1'b0);

    // Configuration A, combinational.
    cfg_reg = '0;
    cfg_alloc[0*NP +: NP] = 20'h0100F; cfg_xor[0] = 1'b1;       // R3 + R4
    cfg_fast[1] = 1'b1; cfg_alloc[1*NP +: NP] = 20'hFFFFF; cfg_xor[1] = 1'b1; // R5 ignores
    cfg_alloc[2*NP +: NP] = 20'hA0100;                          // R3
    cfg_alloc[3*NP +: NP] = 20'h00000;                          // R3 empty -> 0
    sweep_comb("R1/R3/R4/R5/R6", 300);
    rst = 1'b0;
    sweep_comb("R6 comb out of reset", 50);

    // Direct literal and empty-term checks through output 3 (short path, group 12..15).
    cfg_fast = 4'b1000;
    lin = 18'h00400; #1; chk("R1 true literal", q[3], 1'b1);
    lin = 18'h00000; #1; chk("R2 empty terms 13..15", q[3], 1'b0);
    cfg_fast = 4'b0010; cfg_alloc[3*NP +: NP] = 20'h40000; cfg_xor[3] = 1'b0;
    lin = 18'h04000; #1; chk("R1 both forms is 0", q[3], 1'b0);
    lin = 18'h00000; #1; chk("R1 both forms is 0", q[3], 1'b0);

    // Configuration B, combinational.
    cfg_alloc = '0; cfg_xor = '0; cfg_fast = '0;
    cfg_fast[0] = 1'b1;
    cfg_xor[1] = 1'b1; cfg_alloc[1*NP +: NP] = 20'hFFFFF;
    cfg_alloc[2*NP +: NP] = 20'h0FFFF;
    cfg_xor[3] = 1'b1;                                          // XOR with term 19 only
    sweep_comb("R3/R4/R5 config B", 300);
    lin = 18'h00000; #1; chk("R4 xor term alone", q[3], 1'b1);
    lin = 18'h10000; #1; chk("R4 xor term alone", q[3], 1'b0);

    // Registered: codes 0,1,2,3 (3 behaves as 2).
    cfg_clk = {2'd3, 2'd2, 2'd1, 2'd0};
    cfg_reg = 4'hF;
    rst = 1'b1; #1; rst = 1'b0; #3;
    held = '0;
    for (int j = 0; j < 24; j++) begin
      lin = pat(1000 + j); #1;
      for (int o = 0; o < NO; o++) chk("R7 hold on input change", q[o], held[o]);
      #3;
      for (int k = 0; k < 3; k++) begin
        gclk[k] = 1'b1; #1;
        for (int o = 0; o < NO; o++) begin
          if (eff(o) == k) held[o] = out_m(o, lin);
          chk("R7 capture on own clock", q[o], held[o]);
          chk("R9", fb[o], held[o]);
        end
        #1; gclk[k] = 1'b0; #2;
      end
    end

    // Asynchronous reset mid-period; output 1 combinational.
    lin = 18'h00020;
    for (int k = 0; k < 3; k++) pulse(k);
    cfg_reg = 4'b1101; #1;
    rst = 1'b1; #1;
    chk("R8 async clear", q[0], 1'b0);
    chk("R8 async clear", q[2], 1'b0);
    chk("R8 async clear", q[3], 1'b0);
    chk("R8 comb unaffected", q[1], out_m(1, lin));
    #2; rst = 1'b0; #2;
    cfg_reg = 4'hF; #1;
    for (int o = 0; o < NO; o++) chk("R8 cleared state held", q[o], 1'b0);
    pulse(1); #1;
    chk("R7 clock 1 updates output 1", q[1], out_m(1, lin));
    chk("R7 clock 1 leaves output 0", q[0], 1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule